// File: doc/BRIEF.md
# Rank Interleave Decoder

This block turns a channel-relative memory address into the rank that holds it and the address inside that rank. A table of four programmable rank ranges is searched for the range containing the address. The matched range's interleave way count is divided out of the address above an interleave bit, and the residue selects one of four per-range target words. That word supplies the rank number within the channel and an offset subtracted from the compressed address.

The interleave bit depends on the page policy of the channel: closed-page channels interleave on a fine bit, open-page channels on a coarse one. The decode is a two-stage pipeline. Stage one searches the ranges. Stage two does the way arithmetic and the target lookup. When no range claims the address, the block flags a miss and keeps its previous decode on the outputs. The range and target words are inputs held stable by the surrounding logic.

Top module: `rank_ilv_decoder`

## Requirements
- R1: The interleave bit is 6 when `req_close_page` is 1 and 13 when it is 0; it is used for both the rank address compression and the way index.
- R2: A range word is valid when bit 31 is 1. Its upper bound is bits 11:1 shifted left by 29 with the low 29 bits all ones. Range i claims an address when it is valid and the address lies between the lower and upper bounds, both inclusive. The lower bound is 0 for range 0 and the previous range's upper bound, not incremented, for the others. The previous range need not be valid.
- R3: When several ranges claim an address, the lowest-numbered one is used.
- R4: Ways are 1 shifted left by bits 29:28 of the matched range word. The rank address before the offset is `((addr >> s) / ways) << s` OR'd with the low s bits of addr, where s is the interleave bit.
- R5: The way index is `(addr >> s) mod ways`. Its low two bits pick target word `range*4 + index` out of `target_cfg`, word k occupying bits `[32k+31:32k]`.
- R6: The channel rank is target bits 19:16. Target bits 15:2 shifted left by 26 are subtracted from the compressed address, modulo 2^ADDR_W, to give `resp_rank_addr`.
- R7: `resp_dimm` is the channel rank divided by 4 and `resp_rank` is the channel rank modulo 4.
- R8: `resp_valid` is 1 exactly on the second rising edge after a rising edge that sampled `req_valid` high, and 0 otherwise.
- R9: If no range claims the address, `resp_miss` is 1 together with `resp_valid`, and the rank address, channel rank, DIMM and rank outputs keep their previous values.
- R10: After synchronous active-low reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Decode request strobe |
| req_addr | input | ADDR_W | Channel address to decode |
| req_close_page | input | 1 | 1 selects the closed-page interleave bit |
| range_cfg | input | NUM_RANGES*32 | Range words, range i in bits [32i+31:32i] |
| target_cfg | input | NUM_RANGES*NUM_WAYS*32 | Target words, word range*4+way |
| resp_valid | output | 1 | Decode result strobe |
| resp_miss | output | 1 | No range claimed the address |
| resp_chan_rank | output | 4 | Rank number within the channel |
| resp_dimm | output | 2 | DIMM number |
| resp_rank | output | 2 | Rank within the DIMM |
| resp_rank_addr | output | ADDR_W | Rank-local address |

## Verification
Addresses from a multiplicative sweep over twice the mapped space are decoded under every way code, both page policies and two validity patterns. This separates correct compression and way selection from off-by-one shifts and stray high bits, and covers misses above the last range and inside a disabled range. Directed cases put an address exactly on a range bound with the lower range enabled and disabled, which separates an inclusive, non-incremented lower bound from the alternatives and tests priority. Open-page addresses stepping the way index through all four values, and a target with rank 15 and a large offset, expose a swapped target word, a wrong rank field or a missing subtraction wrap.

// File: rtl/rid_pkg.sv
// Package: field positions and policy constants shared by the rank
// interleave decoder. Assumes 32-bit range and target words.
package rid_pkg;
    localparam int REG_W        = 32;
    localparam int VALID_BIT    = 31;
    localparam int LIM_LO       = 1;
    localparam int LIM_BITS     = 11;
    localparam int LIM_SHIFT    = 29;
    localparam int WAYS_LO      = 28;
    localparam int RANK_LO      = 16;
    localparam int RANK_W       = 4;
    localparam int OFF_LO       = 2;
    localparam int OFF_BITS     = 14;
    localparam int OFF_SHIFT    = 26;
    localparam int SHIFT_CLOSED = 6;
    localparam int SHIFT_OPEN   = 13;

    typedef enum logic {PAGE_OPEN = 1'b0, PAGE_CLOSED = 1'b1} page_pol_e;
endpackage

// File: rtl/rid_range_search.sv
// Range search: finds the lowest-numbered valid range whose inclusive
// window [previous upper bound, own upper bound] holds the address.
// Assumes ADDR_W >= LIM_BITS + LIM_SHIFT. Purely combinational.
module rid_range_search
    import rid_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int NUM_RANGES = 4,
    localparam int IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_RANGES*REG_W-1:0] range_cfg,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx,
    output logic [1:0]                  ways_log
);
    logic [ADDR_W-1:0]   upper [NUM_RANGES];
    logic [ADDR_W-1:0]   lower [NUM_RANGES];
    logic [NUM_RANGES-1:0] claim;

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rng
        // Upper bound: limit field at its granule with all-ones low bits.
        assign upper[g] = ADDR_W'({range_cfg[g*REG_W+LIM_LO +: LIM_BITS],
                                   {LIM_SHIFT{1'b1}}});
        if (g == 0) begin : g_first
            assign lower[g] = '0;
        end else begin : g_next
            assign lower[g] = upper[g-1];
        end
        // Claim: valid and inside the inclusive window.
        assign claim[g] = range_cfg[g*REG_W+VALID_BIT] &&
                          (lower[g] <= addr) && (addr <= upper[g]);
    end

    // Priority pick: scan from the top so the lowest index wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_RANGES - 1; i >= 0; i--) begin
            if (claim[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
        ways_log = range_cfg[int'(idx)*REG_W+WAYS_LO +: 2];
    end
endmodule

// File: rtl/rid_rank_math.sv
// Rank arithmetic: removes the power-of-two way count above the
// interleave bit, selects the target word by way index and subtracts
// its offset. Assumes NUM_WAYS is a power of two. Combinational.
module rid_rank_math
    import rid_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int NUM_RANGES = 4,
    parameter int NUM_WAYS   = 4,
    localparam int IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1,
    localparam int WAY_W     = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [ADDR_W-1:0]                    addr,
    input  page_pol_e                            policy,
    input  logic [IDX_W-1:0]                     range_idx,
    input  logic [1:0]                           ways_log,
    input  logic [NUM_RANGES*NUM_WAYS*REG_W-1:0] target_cfg,
    output logic [RANK_W-1:0]                    chan_rank,
    output logic [ADDR_W-1:0]                    rank_addr
);
    logic [ADDR_W-1:0] above;
    logic [ADDR_W-1:0] squeezed;
    logic [ADDR_W-1:0] low_mask;
    logic [WAY_W-1:0]  way;
    logic [REG_W-1:0]  tword;
    logic [ADDR_W-1:0] offset;
    int                sh;

    // Compression: divide the part above the interleave bit by the ways.
    always_comb begin
        sh       = (policy == PAGE_CLOSED) ? SHIFT_CLOSED : SHIFT_OPEN;
        above    = addr >> sh;
        low_mask = (ADDR_W'(1) << sh) - ADDR_W'(1);
        squeezed = ((above >> ways_log) << sh) | (addr & low_mask);
        way      = above[WAY_W-1:0] & WAY_W'((4'd1 << ways_log) - 4'd1);
    end

    // Target lookup and offset subtraction.
    always_comb begin
        tword     = target_cfg[(int'(range_idx)*NUM_WAYS + int'(way))*REG_W +: REG_W];
        chan_rank = tword[RANK_LO +: RANK_W];
        offset    = ADDR_W'({tword[OFF_LO +: OFF_BITS], {OFF_SHIFT{1'b0}}});
        rank_addr = squeezed - offset;
    end
endmodule

// File: rtl/rank_ilv_decoder.sv
// Rank interleave decoder top: stage 1 registers the range search,
// stage 2 registers the rank arithmetic. A miss pulses resp_miss and
// leaves the decode outputs as they were. Configuration inputs must be
// stable while a request is in flight. Synchronous active-low reset.
module rank_ilv_decoder
    import rid_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int NUM_RANGES = 4,
    parameter int NUM_WAYS   = 4,
    localparam int IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    input  logic [ADDR_W-1:0]                    req_addr,
    input  logic                                 req_close_page,
    input  logic [NUM_RANGES*REG_W-1:0]          range_cfg,
    input  logic [NUM_RANGES*NUM_WAYS*REG_W-1:0] target_cfg,
    output logic                                 resp_valid,
    output logic                                 resp_miss,
    output logic [RANK_W-1:0]                    resp_chan_rank,
    output logic [1:0]                           resp_dimm,
    output logic [1:0]                           resp_rank,
    output logic [ADDR_W-1:0]                    resp_rank_addr
);
    logic              srch_hit;
    logic [IDX_W-1:0]  srch_idx;
    logic [1:0]        srch_ways;

    logic              s1_valid;
    logic              s1_hit;
    logic [IDX_W-1:0]  s1_idx;
    logic [1:0]        s1_ways;
    logic [ADDR_W-1:0] s1_addr;
    page_pol_e         s1_policy;

    logic [RANK_W-1:0] m_rank;
    logic [ADDR_W-1:0] m_addr;

    rid_range_search #(.ADDR_W(ADDR_W), .NUM_RANGES(NUM_RANGES)) u_search (
        .addr     (req_addr),
        .range_cfg(range_cfg),
        .hit      (srch_hit),
        .idx      (srch_idx),
        .ways_log (srch_ways)
    );

    // Stage 1: capture the request and the search result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_hit    <= 1'b0;
            s1_idx    <= '0;
            s1_ways   <= '0;
            s1_addr   <= '0;
            s1_policy <= PAGE_OPEN;
        end else begin
            s1_valid <= req_valid;
            if (req_valid) begin
                s1_hit    <= srch_hit;
                s1_idx    <= srch_idx;
                s1_ways   <= srch_ways;
                s1_addr   <= req_addr;
                s1_policy <= page_pol_e'(req_close_page);
            end
        end
    end

    rid_rank_math #(.ADDR_W(ADDR_W), .NUM_RANGES(NUM_RANGES), .NUM_WAYS(NUM_WAYS)) u_math (
        .addr      (s1_addr),
        .policy    (s1_policy),
        .range_idx (s1_idx),
        .ways_log  (s1_ways),
        .target_cfg(target_cfg),
        .chan_rank (m_rank),
        .rank_addr (m_addr)
    );

    // Stage 2: publish the decode, or flag a miss and hold the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid     <= 1'b0;
            resp_miss      <= 1'b0;
            resp_chan_rank <= '0;
            resp_dimm      <= '0;
            resp_rank      <= '0;
            resp_rank_addr <= '0;
        end else begin
            resp_valid <= s1_valid;
            resp_miss  <= s1_valid && !s1_hit;
            if (s1_valid && s1_hit) begin
                resp_chan_rank <= m_rank;
                resp_dimm      <= m_rank[3:2];
                resp_rank      <= m_rank[1:0];
                resp_rank_addr <= m_addr;
            end
        end
    end
endmodule

// File: rtl/rank_ilv_decoder_chk.sv
// Checker for the rank interleave decoder: response timing, miss
// behaviour and reset state. Bound into every decoder instance.
module rank_ilv_decoder_chk #(
    parameter int ADDR_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              resp_valid,
    input logic              resp_miss,
    input logic [3:0]        resp_chan_rank,
    input logic [ADDR_W-1:0] resp_rank_addr
);
    logic rst_seen;

    // Tracks the previous reset level for the post-reset check.
    always_ff @(posedge clk) rst_seen <= rst_n;

    p_latency_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ##2 resp_valid);

    p_latency_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid, 2));

    p_miss_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_miss |-> ($stable(resp_rank_addr) && $stable(resp_chan_rank)));

    p_miss_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_miss |-> resp_valid);

    p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> ($stable(resp_rank_addr) && $stable(resp_chan_rank)));

    // Reset state visible right after the reset edge (R10).
    always @(posedge clk) begin
        if (rst_n && !rst_seen) begin
            p_reset_clear_r10: assert (!resp_valid && !resp_miss &&
                                       resp_rank_addr == '0 && resp_chan_rank == '0);
        end
    end
endmodule

bind rank_ilv_decoder rank_ilv_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .resp_valid    (resp_valid),
    .resp_miss     (resp_miss),
    .resp_chan_rank(resp_chan_rank),
    .resp_rank_addr(resp_rank_addr)
);

// File: tb/rank_ilv_decoder_test.sv
module rank_ilv_decoder_test;
    localparam int AW = 40;
    localparam longint unsigned AMASK = (64'd1 << AW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic              req_close_page = 1'b0;
    logic [127:0]      range_cfg;
    logic [511:0]      target_cfg;
    logic              resp_valid, resp_miss;
    logic [3:0]        resp_chan_rank;
    logic [1:0]        resp_dimm, resp_rank;
    logic [AW-1:0]     resp_rank_addr;

    logic [31:0] rng_m [4];
    logic [31:0] tgt_m [16];

    int checks = 0;
    int errors = 0;
    longint unsigned last_ra = 0;
    int unsigned     last_cr = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 4; i++) range_cfg[i*32 +: 32] = rng_m[i];
        for (int j = 0; j < 16; j++) target_cfg[j*32 +: 32] = tgt_m[j];
    end

    rank_ilv_decoder uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_close_page(req_close_page), .range_cfg(range_cfg),
        .target_cfg(target_cfg), .resp_valid(resp_valid), .resp_miss(resp_miss),
        .resp_chan_rank(resp_chan_rank), .resp_dimm(resp_dimm),
        .resp_rank(resp_rank), .resp_rank_addr(resp_rank_addr)
    );

    task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Range words: limit codes 0,1,3,7; ways code per range; valid mask.
    task automatic set_ranges(input logic [3:0] vmask, input int wc);
        int lc [4] = '{0, 1, 3, 7};
        for (int i = 0; i < 4; i++)
            rng_m[i] = {vmask[i], 1'b0, 2'((wc + i) % 4), 16'd0, 11'(lc[i]), 1'b0};
    endtask

    task automatic set_targets(input int seed);
        for (int j = 0; j < 16; j++)
            tgt_m[j] = {12'd0, 4'((j * 5 + seed) % 16), 14'((j + seed) % 3), 2'd0};
    endtask

    // Independent arithmetic model of the decode.
    task automatic model(input longint unsigned a, input bit cp, output bit hit,
                         output longint unsigned ra, output int unsigned cr);
        longint unsigned prev = 0, lim, ways, w, t, off;
        int sh, ri = -1;
        for (int i = 0; i < 4; i++) begin
            lim = ((longint'(rng_m[i]) >> 1) & 64'h7FF) * (64'd1 << 29) + (64'd1 << 29) - 1;
            if (ri < 0 && rng_m[i][31] && prev <= a && a <= lim) ri = i;
            prev = lim;
        end
        hit = (ri >= 0);
        ra = 0; cr = 0;
        if (hit) begin
            sh   = cp ? 6 : 13;
            ways = 64'd1 << ((rng_m[ri] >> 28) & 3);
            ra   = ((a >> sh) / ways) * (64'd1 << sh) + (a % (64'd1 << sh));
            w    = ((a >> sh) % ways) % 4;
            t    = tgt_m[ri*4 + int'(w)];
            cr   = int'((t >> 16) % 16);
            off  = ((t >> 2) % 16384) * (64'd1 << 26);
            ra   = (ra - off) & AMASK;
        end
    endtask

    task automatic run_one(input longint unsigned a, input bit cp, input string tag);
        bit hit; longint unsigned ra; int unsigned cr;
        model(a, cp, hit, ra, cr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(a); req_close_page = cp;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 early", resp_valid, 0);
        @(negedge clk);
        chk("R8 valid", resp_valid, 1);
        chk("R9 miss flag", resp_miss, !hit);
        if (hit) begin
            chk({tag, " rank_addr"}, resp_rank_addr, ra);
            chk({tag, " chan_rank"}, resp_chan_rank, cr);
            chk("R7 dimm", resp_dimm, cr / 4);
            chk("R7 rank", resp_rank, cr % 4);
            last_ra = ra; last_cr = cr;
        end else begin
            chk("R9 hold addr", resp_rank_addr, last_ra);
            chk("R9 hold rank", resp_chan_rank, last_cr);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_ranges(4'hF, 0);
        set_targets(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 valid", resp_valid, 0);
        chk("R10 miss", resp_miss, 0);
        chk("R10 addr", resp_rank_addr, 0);
        chk("R10 chan_rank", resp_chan_rank, 0);
        chk("R10 dimm/rank", {resp_dimm, resp_rank}, 0);

        // R1: same address, both page policies.
        set_ranges(4'hF, 1);
        run_one(64'h0000_2043, 1'b1, "R1");
        run_one(64'h0000_2043, 1'b0, "R1");
        run_one(64'h0000_6FC0, 1'b1, "R1");
        run_one(64'h0000_6FC0, 1'b0, "R1");

        // R2: bound with range 0 disabled, then just below it.
        set_ranges(4'hE, 0);
        run_one((64'd1 << 29) - 1, 1'b0, "R2");
        run_one((64'd1 << 29) - 2, 1'b0, "R2");
        run_one(64'd1 << 29, 1'b0, "R2");

        // R3: bound with range 0 enabled belongs to range 0.
        set_ranges(4'hF, 0);
        run_one((64'd1 << 29) - 1, 1'b0, "R3");

        // R5: four-way range 0, way index 0..3 in open page.
        set_ranges(4'hF, 2);
        for (int w = 0; w < 4; w++) run_one((longint'(w) << 13) | 64'h55, 1'b0, "R5");

        // R6: rank 15, large offset forcing wrap.
        tgt_m[0] = {12'd0, 4'hF, 14'h3FFF, 2'd0};
        set_ranges(4'hF, 0);
        run_one(64'h0000_1234, 1'b0, "R6");
        run_one(64'h0000_0040, 1'b1, "R6");

        // R4: sweep way codes, policies and validity patterns.
        for (int vp = 0; vp < 2; vp++)
            for (int wc = 0; wc < 4; wc++)
                for (int cp = 0; cp < 2; cp++) begin
                    set_ranges(vp == 0 ? 4'hF : 4'hD, wc);
                    set_targets(wc + vp);
                    for (int k = 0; k < 300; k++)
                        run_one((longint'(k) * 64'h9E37_79B1) & 64'h1_FFFF_FFFF, cp[0], "R4");
                end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule